// File: doc/BRIEF.md
# Byte-Lane Bus Cycle Sequencer

The sequencer turns CPU-side memory requests into bus cycles for a 16-bit memory built from two byte-wide banks: an even bank on the low data lane and an odd bank on the high data lane. A request carries a 20-bit byte address, a byte/word size flag, a read/write flag and 16 bits of write data. The request is accepted through a valid/ready handshake.

For each request the block drives one or two single-clock bus cycles. Each cycle carries an address, an active-low high-byte enable, address bit 0, the two bank selects, the read or write strobe, and write data steered onto the right lane. A word at an odd address cannot be moved in one cycle, so it is split. The low byte goes first, on the high lane at the odd address. The high byte follows on the low lane at the next address. Read bytes are gathered from whichever lanes carried them, and the assembled result is presented with a one-cycle done pulse.

Top module: `byte_lane_seq`

## Requirements
- R1: A byte request at an even address gives one bus cycle with bus_bhe_n=1 and bus_a0=0. Write data byte [7:0] goes on bus_dout[7:0], and bus_dout[15:8] is 0. A read returns {8'h00, bus_din[7:0]}.
- R2: A word request at an even address gives one bus cycle with bus_bhe_n=0 and bus_a0=0. Write data goes out unchanged on bus_dout[15:0]. A read returns bus_din[15:0].
- R3: A byte request at an odd address gives one bus cycle with bus_bhe_n=0 and bus_a0=1. Write byte [7:0] goes on bus_dout[15:8], and bus_dout[7:0] is 0. A read returns {8'h00, bus_din[15:8]}.
- R4: A word request at an odd address A gives two consecutive bus cycles.
  - The first is at A, with bus_bhe_n=0 and bus_a0=1. It carries write byte [7:0] on bus_dout[15:8], with bus_dout[7:0]=0.
  - The second is at A+1 modulo 2^20, with bus_bhe_n=1 and bus_a0=0. It carries write byte [15:8] on bus_dout[7:0], with bus_dout[15:8]=0.
- R5: For a split word read, bus_din[15:8] sampled in the first cycle becomes result [7:0], and bus_din[7:0] sampled in the second becomes result [15:8].
- R6: During a bus cycle, sel_even=1 exactly when bus_a0=0 and sel_odd=1 exactly when bus_bhe_n=0. Outside bus cycles both selects are 0.
- R7: bank_addr always equals bus_addr[19:1].
- R8: A request is accepted on a clock edge where req_valid and req_ready are both 1, and its first bus cycle occupies the next clock. req_ready is 0 from that clock until the clock after the last bus cycle. In that clock, done is 1 for exactly one cycle with rdata valid, and req_ready is 1 again, so the next request may be accepted in the done cycle.
- R9: Every bus cycle lasts one clock. bus_rd=1 for reads and bus_wr=1 for writes, and the two are never 1 together.
- R10: After synchronous reset, req_ready=1, done=0, and bus_rd, bus_wr, sel_even and sel_odd are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; byte requests use [7:0] |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |
| bus_addr | output | 20 | Bus cycle byte address |
| bank_addr | output | 19 | Address seen by both banks (bits 19:1) |
| bus_bhe_n | output | 1 | High-byte enable, active low |
| bus_a0 | output | 1 | Address bit 0 of the cycle |
| sel_even | output | 1 | Even (low lane) bank select |
| sel_odd | output | 1 | Odd (high lane) bank select |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_dout | output | 16 | Lane-steered write data |
| bus_din | input | 16 | Read data from the banks |

## Verification
Two functions can fall in the same clock. One is the completion of a request: the done pulse with its read result. The other is the acceptance of the next request. The bench provokes this by raising req_valid with a new request in the very cycle done is seen, and only sometimes leaves idle gaps between requests. It then judges the second request by its full cycle pattern and result: its first bus cycle must follow directly, and the first result must not be corrupted by the overlapping acceptance.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  typedef struct packed {
    logic bhe_n;
    logic a0;
    logic split;
  } lane_plan_t;
endpackage

// File: rtl/bls_lane_planner.sv
module bls_lane_planner
  import bls_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          word,
  input  logic [DW-1:0] wdata,
  input  logic          second,
  output logic [AW-1:0] cyc_addr,
  output lane_plan_t    plan,
  output logic [DW-1:0] dout
);
  localparam int BW = DW / 2;

  always_comb begin
    plan.split = word & addr[0];
    cyc_addr   = second ? addr + AW'(1) : addr;
    plan.a0    = cyc_addr[0];
    dout       = '0;
    if (second) begin
      plan.bhe_n  = 1'b1;
      dout[BW-1:0] = wdata[DW-1:BW];
    end else if (addr[0]) begin
      plan.bhe_n  = 1'b0;
      dout[DW-1:BW] = wdata[BW-1:0];
    end else if (word) begin
      plan.bhe_n  = 1'b0;
      dout        = wdata;
    end else begin
      plan.bhe_n  = 1'b1;
      dout[BW-1:0] = wdata[BW-1:0];
    end
  end
endmodule

// File: rtl/bls_read_merge.sv
module bls_read_merge #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          second,
  input  logic          cyc_a0,
  input  logic          cyc_bhe_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] result
);
  localparam int BW = DW / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (cap_en) begin
      if (second)
        result[DW-1:BW] <= din[BW-1:0];
      else if (cyc_a0)
        result <= {{BW{1'b0}}, din[DW-1:BW]};
      else if (!cyc_bhe_n)
        result <= din;
      else
        result <= {{BW{1'b0}}, din[BW-1:0]};
    end
  end

  AST_SECOND_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (cap_en && second) |=> result[BW-1:0] == $past(result[BW-1:0])); // R5
endmodule

// File: rtl/byte_lane_seq.sv
module byte_lane_seq
  import bls_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic [AW-2:0] bank_addr,
  output logic          bus_bhe_n,
  output logic          bus_a0,
  output logic          sel_even,
  output logic          sel_odd,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din
);
  phase_e        phase;
  logic [AW-1:0] held_addr;
  logic          held_word;
  logic          held_write;
  logic [DW-1:0] held_wdata;
  logic          held_split;

  logic [AW-1:0] src_addr;
  logic          src_word;
  logic [DW-1:0] src_wdata;
  logic          src_second;
  logic [AW-1:0] nxt_addr;
  lane_plan_t    nxt_plan;
  logic [DW-1:0] nxt_dout;

  always_comb begin
    src_second = (phase == PH_FIRST);
    if (phase == PH_IDLE) begin
      src_addr  = req_addr;
      src_word  = req_word;
      src_wdata = req_wdata;
    end else begin
      src_addr  = held_addr;
      src_word  = held_word;
      src_wdata = held_wdata;
    end
  end

  bls_lane_planner #(.AW(AW), .DW(DW)) u_plan (
    .addr     (src_addr),
    .word     (src_word),
    .wdata    (src_wdata),
    .second   (src_second),
    .cyc_addr (nxt_addr),
    .plan     (nxt_plan),
    .dout     (nxt_dout)
  );

  bls_read_merge #(.DW(DW)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (bus_rd),
    .second    (phase == PH_SECOND),
    .cyc_a0    (bus_a0),
    .cyc_bhe_n (bus_bhe_n),
    .din       (bus_din),
    .result    (rdata)
  );

  assign bank_addr = bus_addr[AW-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      req_ready  <= 1'b1;
      done       <= 1'b0;
      bus_rd     <= 1'b0;
      bus_wr     <= 1'b0;
      sel_even   <= 1'b0;
      sel_odd    <= 1'b0;
      bus_addr   <= '0;
      bus_bhe_n  <= 1'b1;
      bus_a0     <= 1'b0;
      bus_dout   <= '0;
      held_addr  <= '0;
      held_word  <= 1'b0;
      held_write <= 1'b0;
      held_wdata <= '0;
      held_split <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            held_addr  <= req_addr;
            held_word  <= req_word;
            held_write <= req_write;
            held_wdata <= req_wdata;
            held_split <= nxt_plan.split;
            bus_addr   <= nxt_addr;
            bus_bhe_n  <= nxt_plan.bhe_n;
            bus_a0     <= nxt_plan.a0;
            sel_even   <= !nxt_plan.a0;
            sel_odd    <= !nxt_plan.bhe_n;
            bus_dout   <= nxt_dout;
            bus_rd     <= !req_write;
            bus_wr     <= req_write;
            req_ready  <= 1'b0;
            phase      <= PH_FIRST;
          end
        end
        PH_FIRST: begin
          if (held_split) begin
            bus_addr  <= nxt_addr;
            bus_bhe_n <= nxt_plan.bhe_n;
            bus_a0    <= nxt_plan.a0;
            sel_even  <= !nxt_plan.a0;
            sel_odd   <= !nxt_plan.bhe_n;
            bus_dout  <= nxt_dout;
            bus_rd    <= !held_write;
            bus_wr    <= held_write;
            phase     <= PH_SECOND;
          end else begin
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b0;
            sel_even  <= 1'b0;
            sel_odd   <= 1'b0;
            done      <= 1'b1;
            req_ready <= 1'b1;
            phase     <= PH_IDLE;
          end
        end
        PH_SECOND: begin
          bus_rd    <= 1'b0;
          bus_wr    <= 1'b0;
          sel_even  <= 1'b0;
          sel_odd   <= 1'b0;
          done      <= 1'b1;
          req_ready <= 1'b1;
          phase     <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R9
  AST_SEL_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> (sel_even || sel_odd)); // R6
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd || bus_wr) |-> !(sel_even || sel_odd)); // R6
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && (bus_rd || bus_wr))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_SPLIT_NEXT_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(phase == PH_SECOND) |-> bus_addr == $past(bus_addr) + AW'(1)); // R4
endmodule

// File: tb/byte_lane_seq_bench.sv
`timescale 1ns/1ps
module byte_lane_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [15:0] rdata;
  logic [19:0] bus_addr;
  logic [18:0] bank_addr;
  logic        bus_bhe_n, bus_a0, sel_even, sel_odd, bus_rd, bus_wr;
  logic [15:0] bus_dout;
  logic [15:0] bus_din;

  logic [7:0] even_mem [256];
  logic [7:0] odd_mem  [256];
  logic [7:0] ref_mem  [512];

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  byte_lane_seq u_byte_lane_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .bank_addr(bank_addr), .bus_bhe_n(bus_bhe_n), .bus_a0(bus_a0),
    .sel_even(sel_even), .sel_odd(sel_odd), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  assign bus_din = {odd_mem[bank_addr[7:0]], even_mem[bank_addr[7:0]]};

  always @(posedge clk) begin
    if (bus_wr && sel_even) even_mem[bank_addr[7:0]] <= bus_dout[7:0];
    if (bus_wr && sel_odd)  odd_mem[bank_addr[7:0]]  <= bus_dout[15:8];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request, starting at a negedge with ready expected high; returns at the done negedge.
  task automatic run_req(input logic [19:0] a, input logic w, input logic wr, input logic [15:0] wd);
    logic        split = w & a[0];
    int          n_exp = split ? 2 : 1;
    int          n = 0;
    string       tag;
    logic [19:0] ca;
    logic        e_bhe;
    logic [15:0] e_dout;
    logic [15:0] e_rd;
    tag = split ? "R4" : (a[0] ? "R3" : (w ? "R2" : "R1"));
    check("R8 ready before accept", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_addr = $urandom; req_word = $urandom; req_write = $urandom; req_wdata = $urandom;
    while (!done && n < 4) begin
      ca = (n == 0) ? a : a + 20'd1;
      if (n == 1) e_bhe = 1'b1;
      else e_bhe = a[0] ? 1'b0 : ~w;
      if (n == 1) e_dout = {8'h00, wd[15:8]};
      else if (a[0]) e_dout = {wd[7:0], 8'h00};
      else if (w) e_dout = wd;
      else e_dout = {8'h00, wd[7:0]};
      check({tag, " addr"}, {12'd0, bus_addr}, {12'd0, ca});
      check({tag, " bhe_n/a0"}, {30'd0, bus_bhe_n, bus_a0}, {30'd0, e_bhe, ca[0]});
      check("R6 selects", {30'd0, sel_even, sel_odd}, {30'd0, ~ca[0], ~e_bhe});
      check("R7 bank addr", {13'd0, bank_addr}, {13'd0, ca[19:1]});
      check("R9 strobes", {30'd0, bus_rd, bus_wr}, {30'd0, ~wr, wr});
      check("R8 ready low", {31'd0, req_ready}, 32'd0);
      if (wr) check({tag, " write lanes"}, {16'd0, bus_dout}, {16'd0, e_dout});
      n++;
      @(negedge clk);
    end
    check({tag, " R8 cycle count"}, n, n_exp);
    check("R8 done", {31'd0, done}, 32'd1);
    check("R9 strobes off", {30'd0, bus_rd, bus_wr}, 32'd0);
    if (wr) begin
      ref_mem[a[8:0]] = wd[7:0];
      if (w) ref_mem[9'(a[8:0] + 9'd1)] = wd[15:8];
    end else begin
      e_rd = w ? {ref_mem[9'(a[8:0] + 9'd1)], ref_mem[a[8:0]]} : {8'h00, ref_mem[a[8:0]]};
      check(split ? "R5 read" : {tag, " read"}, {16'd0, rdata}, {16'd0, e_rd});
    end
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    for (int i = 0; i < 256; i++) begin
      even_mem[i] = 8'($urandom);
      odd_mem[i]  = 8'($urandom);
      ref_mem[2*i]   = even_mem[i];
      ref_mem[2*i+1] = odd_mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 ready", {31'd0, req_ready}, 32'd1);
    check("R10 done", {31'd0, done}, 32'd0);
    check("R10 strobes/selects", {28'd0, bus_rd, bus_wr, sel_even, sel_odd}, 32'd0);
    // directed corners
    run_req(20'h00010, 1'b0, 1'b1, 16'hAA55); // R1 write
    run_req(20'h00010, 1'b0, 1'b0, 16'h0000); // R1 read
    run_req(20'h00020, 1'b1, 1'b1, 16'h1234); // R2
    run_req(20'h00020, 1'b1, 1'b0, 16'h0000);
    run_req(20'h00031, 1'b0, 1'b1, 16'hFF6C); // R3
    run_req(20'h00031, 1'b0, 1'b0, 16'h0000);
    run_req(20'h00041, 1'b1, 1'b1, 16'hBEEF); // R4
    run_req(20'h00041, 1'b1, 1'b0, 16'h0000); // R5
    run_req(20'hFFFFF, 1'b1, 1'b1, 16'hC0DE); // R4 wrap to 0
    run_req(20'hFFFFF, 1'b1, 1'b0, 16'h0000); // R5 wrap
    for (int k = 0; k < 400; k++) begin
      run_req(20'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        check("R8 idle gap", {28'd0, done, bus_rd, bus_wr, sel_even}, 32'd0);
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule